// File: doc/BRIEF.md
# Startup Gate and Free-Running Event Counter

This block sits beside a small processor core and decides when that core may begin to execute. After power-on the core stays parked until the start request has been seen high for long enough. The block then raises a core-running flag that nothing short of a new power-on can clear. In the build without cycle counting, the wait is dropped and the first high sample of the request is enough.

Once the core runs, the start request takes a second job: it gates a 32-bit counter. The build option `CYCLE_MODE` sets what the counter counts. With a value of 1 it counts clock cycles and holds the low word of the cycle count. With a value of 0 it counts retired instructions, one per retire pulse. The parameter `TAP` selects a power of two in the range 14 to 31. Each time the counter moves past a multiple of 2^TAP, the block raises a sticky tick request, which a time-keeping block elsewhere uses to step a wider time value. A `TAP` of 0 turns the tick off.

`por_rst` is the power-on reset. It is synchronous and active-high, and it stands for a power cycle. There is no other way back to the parked state.

Top module: `boot_gate_counter`

## Requirements
- R1: While `por_rst` is sampled high, the block sets `core_run` to 0, `count_val` to 0 and `tick_req` to 0 at the next edge.
- R2: With `CYCLE_MODE`=1, `core_run` rises at the clock edge that samples the 128th consecutive high `start_req`. After 127 consecutive high samples it is still low.
- R3: With `CYCLE_MODE`=1, a single low sample of `start_req` before core-running restarts the qualification. 127 highs, then one low, then fewer than 128 highs leave `core_run` low.
- R4: With `CYCLE_MODE`=0, `core_run` rises at the first edge that samples `start_req` high.
- R5: Once `core_run` is 1, it stays 1 whatever `start_req` does, until `por_rst`.
- R6: While `core_run` is 0, `count_val` is 0 and `tick_req` is 0.
- R7: With `CYCLE_MODE`=1 and `core_run` high, `count_val` gains 1 at every edge that samples `start_req` high. At other edges it holds. `retire_pulse` has no effect.
- R8: With `CYCLE_MODE`=0 and `core_run` high, `count_val` gains 1 only at edges that sample both `start_req` and `retire_pulse` high. At other edges it holds.
- R9: With `TAP` from 14 to 31, `tick_req` is set at the edge where an increment takes `count_val[TAP-1:0]` from all ones to zero. It then stays set until acknowledged.
- R10: `tick_req` clears at an edge that samples `tick_ack` high. If the same edge also sets it (R9), it stays set.
- R11: With `TAP`=0, `tick_req` stays 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| por_rst | input | 1 | Power-on reset, synchronous, active-high |
| start_req | input | 1 | Startup request, then count enable once running |
| retire_pulse | input | 1 | One per retired instruction (counted only when `CYCLE_MODE`=0) |
| tick_ack | input | 1 | Clears the tick request |
| core_run | output | 1 | Core may execute |
| count_val | output | CNT_W | Counter value |
| tick_req | output | 1 | Sticky timer-increment request |

## Verification
The checker assumes that `por_rst` is held high from time zero until the first clock edges. It also assumes that `start_req`, `retire_pulse` and `tick_ack` are synchronous to `clk`, so each has a single defined value at every edge. The bench drives every input on the falling edge and asserts `por_rst` at the very start, so both conditions always hold. Beyond that, the stimulus is unconstrained: the start request drops freely both inside and after qualification, and acknowledges arrive at random. At each tap crossing the bench deliberately raises an acknowledge, so that the set-versus-clear collision always occurs.

// File: rtl/bgc_pkg.sv
package bgc_pkg;

    localparam int unsigned TAP_MIN      = 14;
    localparam int unsigned TAP_MAX      = 31;
    localparam int unsigned QUAL_DEFAULT = 128;

    // Per-cycle counter event carried from the counter to the tick logic.
    typedef struct packed {
        logic step;     // counter advances at this edge
        logic enabled;  // core is running
    } cnt_evt_t;

    // Startup gate phase.
    typedef enum logic {
        PH_PARKED  = 1'b0,
        PH_RUNNING = 1'b1
    } run_phase_e;

    function automatic bit tap_active(input int unsigned tap);
        return (tap >= TAP_MIN) && (tap <= TAP_MAX);
    endfunction

endpackage

// File: rtl/bgc_qualifier.sv
module bgc_qualifier
    import bgc_pkg::*;
#(
    parameter int unsigned CYCLE_MODE  = 1,
    parameter int unsigned QUAL_CYCLES = QUAL_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic running
);
    localparam int unsigned QW   = $clog2(QUAL_CYCLES);
    localparam logic [QW-1:0] QMAX = QW'(QUAL_CYCLES - 1);

    logic [QW-1:0] run_len;
    run_phase_e    phase;
    logic          qualified;

    // A debounced start in cycle mode, a bare start otherwise.
    always_comb begin
        if (CYCLE_MODE != 0) begin
            qualified = start && (run_len == QMAX);
        end else begin
            qualified = start;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
            phase   <= PH_PARKED;
        end else if (phase == PH_PARKED) begin
            if (!start) begin
                run_len <= '0;
            end else if (run_len != QMAX) begin
                run_len <= run_len + 1'b1;
            end
            if (qualified) begin
                phase <= PH_RUNNING;
            end
        end
    end

    assign running = (phase == PH_RUNNING);

endmodule

// File: rtl/bgc_counter.sv
module bgc_counter
    import bgc_pkg::*;
#(
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned CYCLE_MODE = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             running,
    input  logic             enable,
    input  logic             retire,
    output logic [CNT_W-1:0] value,
    output cnt_evt_t         evt
);
    localparam logic CYC = (CYCLE_MODE != 0);

    always_comb begin
        evt.enabled = running;
        evt.step    = running && enable && (CYC || retire);
    end

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            value <= '0;
        end else if (evt.step) begin
            value <= value + 1'b1;
        end
    end

endmodule

// File: rtl/bgc_tick.sv
module bgc_tick
    import bgc_pkg::*;
#(
    parameter int unsigned TAP  = 14,
    parameter int unsigned TAPW = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  cnt_evt_t        evt,
    input  logic [TAPW-1:0] low_bits,
    input  logic            ack,
    output logic            tick
);
    generate
        if (tap_active(TAP)) begin : g_tap
            logic crossing;
            logic tick_q;

            // Increment out of an all-ones low field carries into bit TAP.
            assign crossing = evt.enabled && evt.step && (&low_bits);

            always_ff @(posedge clk) begin
                if (rst) begin
                    tick_q <= 1'b0;
                end else begin
                    tick_q <= crossing || (tick_q && !ack);
                end
            end
            assign tick = tick_q;
        end else begin : g_notap
            assign tick = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/boot_gate_counter.sv
module boot_gate_counter
    import bgc_pkg::*;
#(
    parameter int unsigned CYCLE_MODE  = 1,
    parameter int unsigned TAP         = 14,
    parameter int unsigned QUAL_CYCLES = QUAL_DEFAULT,
    parameter int unsigned CNT_W       = 32
) (
    input  logic             clk,
    input  logic             por_rst,
    input  logic             start_req,
    input  logic             retire_pulse,
    input  logic             tick_ack,
    output logic             core_run,
    output logic [CNT_W-1:0] count_val,
    output logic             tick_req
);
    localparam int unsigned TAPW = tap_active(TAP) ? TAP : 1;

    cnt_evt_t evt;

    bgc_qualifier #(
        .CYCLE_MODE (CYCLE_MODE),
        .QUAL_CYCLES(QUAL_CYCLES)
    ) u_qual (
        .clk    (clk),
        .rst    (por_rst),
        .start  (start_req),
        .running(core_run)
    );

    bgc_counter #(
        .CNT_W     (CNT_W),
        .CYCLE_MODE(CYCLE_MODE)
    ) u_cnt (
        .clk    (clk),
        .rst    (por_rst),
        .running(core_run),
        .enable (start_req),
        .retire (retire_pulse),
        .value  (count_val),
        .evt    (evt)
    );

    bgc_tick #(
        .TAP (TAP),
        .TAPW(TAPW)
    ) u_tick (
        .clk     (clk),
        .rst     (por_rst),
        .evt     (evt),
        .low_bits(count_val[TAPW-1:0]),
        .ack     (tick_ack),
        .tick    (tick_req)
    );

endmodule

// File: rtl/bgc_checker.sv
module bgc_checker
    import bgc_pkg::*;
#(
    parameter int unsigned CYCLE_MODE = 1,
    parameter int unsigned TAP        = 14,
    parameter int unsigned CNT_W      = 32
) (
    input logic             clk,
    input logic             por_rst,
    input logic             start_req,
    input logic             retire_pulse,
    input logic             tick_ack,
    input logic             core_run,
    input logic [CNT_W-1:0] count_val,
    input logic             tick_req
);
    localparam logic CYC = (CYCLE_MODE != 0);

    // R5
    run_sticky_chk: assert property (@(posedge clk) disable iff (por_rst)
        core_run |=> core_run);

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (por_rst)
        !core_run |-> (count_val == '0) && !tick_req);

    // R2
    run_rise_chk: assert property (@(posedge clk) disable iff (por_rst)
        $rose(core_run) |-> $past(start_req));

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (por_rst)
        (core_run && start_req && (CYC || retire_pulse))
        |=> count_val == CNT_W'($past(count_val) + 1'b1));

    // R8
    count_hold_chk: assert property (@(posedge clk) disable iff (por_rst)
        (core_run && !(start_req && (CYC || retire_pulse)))
        |=> $stable(count_val));

    // R10
    tick_clear_chk: assert property (@(posedge clk) disable iff (por_rst)
        $fell(tick_req) |-> $past(tick_ack));

    generate
        if (tap_active(TAP)) begin : g_tap_chk
            // R9
            tick_set_chk: assert property (@(posedge clk) disable iff (por_rst)
                $rose(tick_req) |-> (count_val[TAP-1:0] == '0));
        end else begin : g_notap_chk
            // R11
            tick_off_chk: assert property (@(posedge clk) disable iff (por_rst)
                !tick_req);
        end
    endgenerate

endmodule

bind boot_gate_counter bgc_checker #(
    .CYCLE_MODE(CYCLE_MODE),
    .TAP       (TAP),
    .CNT_W     (CNT_W)
) u_bgc_checker (
    .clk         (clk),
    .por_rst     (por_rst),
    .start_req   (start_req),
    .retire_pulse(retire_pulse),
    .tick_ack    (tick_ack),
    .core_run    (core_run),
    .count_val   (count_val),
    .tick_req    (tick_req)
);

// File: tb/boot_gate_counter_bench.sv
module boot_gate_counter_bench;

    localparam int unsigned TAP_A = 14;

    logic clk = 1'b0;
    logic por_rst = 1'b1;
    logic start_req = 1'b0;
    logic retire_pulse = 1'b0;
    logic tick_ack = 1'b0;

    logic        run_a, tick_a, run_b, tick_b;
    logic [31:0] cnt_a, cnt_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    // Cycle-counting build, tick at 2^14.
    boot_gate_counter #(.CYCLE_MODE(1), .TAP(TAP_A)) u_boot_gate_counter (
        .clk(clk), .por_rst(por_rst), .start_req(start_req),
        .retire_pulse(retire_pulse), .tick_ack(tick_ack),
        .core_run(run_a), .count_val(cnt_a), .tick_req(tick_a));

    // Retire-counting build, tick disabled.
    boot_gate_counter #(.CYCLE_MODE(0), .TAP(0)) u_boot_gate_counter_rc (
        .clk(clk), .por_rst(por_rst), .start_req(start_req),
        .retire_pulse(retire_pulse), .tick_ack(tick_ack),
        .core_run(run_b), .count_val(cnt_b), .tick_req(tick_b));

    // Expected-state model built from the requirements.
    int unsigned m_q;
    bit          m_run_a, m_tick_a, m_run_b, m_tick_b;
    logic [31:0] m_cnt_a, m_cnt_b;

    function automatic bit crosses(input logic [31:0] c);
        return c[TAP_A-1:0] == {TAP_A{1'b1}};
    endfunction

    always @(posedge clk) begin
        if (por_rst) begin
            m_q = 0; m_run_a = 0; m_tick_a = 0; m_cnt_a = '0;
            m_run_b = 0; m_tick_b = 0; m_cnt_b = '0;
        end else begin
            // build A
            m_tick_a = (m_run_a && start_req && crosses(m_cnt_a)) || (m_tick_a && !tick_ack);
            m_cnt_a  = !m_run_a ? 32'd0 : (start_req ? m_cnt_a + 32'd1 : m_cnt_a);
            if (!m_run_a) begin
                m_run_a = start_req && (m_q == 127);
                m_q = !start_req ? 0 : ((m_q != 127) ? m_q + 1 : m_q);
            end
            // build B
            m_cnt_b = !m_run_b ? 32'd0 : ((start_req && retire_pulse) ? m_cnt_b + 32'd1 : m_cnt_b);
            m_run_b = m_run_b || start_req;
            m_tick_b = 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 R3 R5 run A", {31'd0, run_a}, {31'd0, m_run_a});
        chk("R6 R7 count A", cnt_a, m_cnt_a);
        chk("R9 R10 tick A", {31'd0, tick_a}, {31'd0, m_tick_a});
        chk("R4 R5 run B", {31'd0, run_b}, {31'd0, m_run_b});
        chk("R6 R8 count B", cnt_b, m_cnt_b);
        chk("R11 tick B", {31'd0, tick_b}, 32'd0);
    endtask

    task automatic cyc();
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int unsigned seed_init;
        int unsigned collisions;
        seed_init = $urandom(32'd2718);
        collisions = 0;

        repeat (3) cyc();
        // R1: reset state
        chk("R1 run", {31'd0, run_a}, 32'd0);
        chk("R1 count", cnt_a, 32'd0);
        chk("R1 tick", {31'd0, tick_a}, 32'd0);
        por_rst = 1'b0;
        cyc();

        // R3: 127 highs then one low
        start_req = 1'b1;
        repeat (127) cyc();
        chk("R3 not yet running", {31'd0, run_a}, 32'd0);
        chk("R4 first high starts B", {31'd0, run_b}, 32'd1);
        start_req = 1'b0;
        cyc();
        start_req = 1'b1;
        repeat (100) cyc();
        chk("R3 restart after low", {31'd0, run_a}, 32'd0);
        chk("R6 count idle", cnt_a, 32'd0);

        // random start pattern while parked (R3 R6)
        for (int i = 0; i < 300; i++) begin
            start_req = ($urandom % 8) != 0;
            retire_pulse = $urandom % 2;
            cyc();
        end
        chk("R3 random parked", {31'd0, run_a}, 32'd0);

        // R2: exactly 128 highs
        start_req = 1'b0;
        cyc();
        start_req = 1'b1;
        repeat (127) cyc();
        chk("R2 after 127", {31'd0, run_a}, 32'd0);
        cyc();
        chk("R2 after 128", {31'd0, run_a}, 32'd1);
        chk("R6 count at rise", cnt_a, 32'd0);

        // running phase: random enables, retires and acks
        for (int i = 0; i < 40000; i++) begin
            start_req    = ($urandom % 16) != 0;
            retire_pulse = $urandom % 2;
            tick_ack     = ($urandom % 64) == 0;
            if (crosses(m_cnt_a)) begin
                // R10: set and clear at the same edge
                start_req = 1'b1;
                tick_ack  = 1'b1;
                collisions++;
            end
            cyc();
        end
        tick_ack = 1'b0;
        chk("R10 collisions seen", {31'd0, collisions >= 2}, 32'd1);
        chk("R9 count past tap", {31'd0, m_cnt_a >= 32'd32768}, 32'd1);

        // R5: start low leaves running set, count holds (R7)
        start_req = 1'b0;
        repeat (5) cyc();
        chk("R5 run held A", {31'd0, run_a}, 32'd1);
        chk("R5 run held B", {31'd0, run_b}, 32'd1);

        // R1: power cycle
        por_rst = 1'b1;
        cyc();
        chk("R1 run after por", {31'd0, run_a}, 32'd0);
        chk("R1 count after por", cnt_b, 32'd0);
        chk("R1 tick after por", {31'd0, tick_a}, 32'd0);
        finish_run();
    end

endmodule